// File: doc/BRIEF.md
# Qualified performance event counter

This block is one hardware performance-monitoring counter. Each cycle it receives the number of times a monitored event occurred in that cycle (0 to 15), the current privilege level, and a global enable. A configuration word, loaded through a single-cycle write strobe, decides which of these cycles count and by how much. The configuration holds user and kernel enables, an 8-bit threshold, an invert bit and an edge-detect bit.

With the threshold at zero and no qualifiers set, the counter adds the raw occurrence count. With a threshold, each cycle contributes at most one, depending on a comparison against the threshold. Invert flips that comparison. Edge detect counts only the cycles where the comparison result rises. The accumulator wraps silently and leaves a sticky overflow flag. The flag and the edge history both clear on the next configuration write.

Top module: `perf_qual_counter`

## Requirements
- R1: No increment occurs in a cycle where `count_en` is low, or where the privilege level is not allowed. Level 0 is allowed only with the kernel enable set. Levels 1, 2 and 3 are allowed only with the user enable set.
- R2: With threshold 0, invert clear and edge clear, each allowed cycle adds `evt_inc` to the counter.
- R3: With a nonzero threshold and invert and edge both clear, each allowed cycle adds one when `evt_inc >= threshold`, and adds zero otherwise.
- R4: With invert set and edge clear, each allowed cycle adds one when the compare condition is false. For a nonzero threshold that condition is `evt_inc >= threshold`; for threshold 0 it is `evt_inc != 0`.
- R5: With edge set and a nonzero threshold, an allowed cycle adds one only when the condition (after any inversion) is true in this cycle and was false in the previous cycle. The history bit is updated every cycle, whether or not that cycle is allowed.
- R6: Edge set together with threshold 0 is an illegal configuration, and no cycle counts.
- R7: The counter is `CNT_W` bits wide and wraps modulo 2^CNT_W. A wrap sets `ovf`, which then stays high.
- R8: In the cycle where `cfg_we` is high, the counter holds its value. That write loads the new fields, clears `ovf`, and clears the edge history.
- R9: A synchronous reset clears the counter, `ovf`, the edge history and all configuration fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_usr_en | input | 1 | Allow counting at privilege levels 1 to 3 |
| cfg_krn_en | input | 1 | Allow counting at privilege level 0 |
| cfg_inv | input | 1 | Invert the compare condition |
| cfg_edge | input | 1 | Count only rising edges of the condition |
| cfg_thr | input | 8 | Threshold |
| count_en | input | 1 | Global enable |
| evt_inc | input | 4 | Event occurrences this cycle |
| priv_lvl | input | 2 | Current privilege level |
| cnt_val | output | CNT_W | Counter value |
| ovf | output | 1 | Sticky wrap flag |

## Verification
The hardest state to reach is the edge history. It is an internal bit that is never visible at the ports, and it advances even in cycles that are gated off. The bench tests it by running every configuration against occurrence counts in a scrambled order, so the condition toggles often. It also mixes in privilege levels that are not allowed, and its model keeps the history bit moving through those gated cycles. Wrap is reached by building the bench with an 8-bit counter and feeding it the maximum occurrence count.

// File: rtl/pqc_pkg.sv
package pqc_pkg;
  localparam int unsigned THR_W = 8;

  typedef struct packed {
    logic             usr_en;
    logic             krn_en;
    logic             inv;
    logic             edge_det;
    logic [THR_W-1:0] thr;
  } pqc_cfg_t;
endpackage

// File: rtl/pqc_cfg_reg.sv
module pqc_cfg_reg
  import pqc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     we,
  input  pqc_cfg_t cfg_in,
  output pqc_cfg_t cfg_q
);
  always_ff @(posedge clk) begin
    if (rst)     cfg_q <= '0;
    else if (we) cfg_q <= cfg_in;
  end
endmodule

// File: rtl/pqc_qualifier.sv
module pqc_qualifier
  import pqc_pkg::*;
#(
  parameter int unsigned INC_W = 4,
  parameter int unsigned PL_W  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  pqc_cfg_t         cfg,
  input  logic [INC_W-1:0] evt,
  input  logic [PL_W-1:0]  priv,
  input  logic             en,
  output logic [INC_W-1:0] inc_amt
);
  localparam int unsigned CMP_W = (INC_W > THR_W) ? INC_W : THR_W;

  logic thr_zero, hit, cond, prev_q, rise, priv_ok, gate;

  always_comb begin
    thr_zero = (cfg.thr == '0);
    hit      = thr_zero ? (evt != '0)
                        : (CMP_W'(evt) >= CMP_W'(cfg.thr));
    cond     = hit ^ cfg.inv;
    rise     = cond & ~prev_q;
    priv_ok  = (priv == '0) ? cfg.krn_en : cfg.usr_en;
    gate     = en & priv_ok & ~clr;
    if (!gate)                          inc_amt = '0;
    else if (cfg.edge_det)              inc_amt = thr_zero ? '0 : INC_W'(rise);
    else if (thr_zero && !cfg.inv)      inc_amt = evt;
    else                                inc_amt = INC_W'(cond);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) prev_q <= 1'b0;
    else            prev_q <= cond;
  end

  // R6: illegal edge configuration never contributes
  assert_illegal_edge_R6: assert property (@(posedge clk) disable iff (rst)
    (cfg.edge_det && cfg.thr == '0) |-> (inc_amt == '0));

  // R3: thresholded modes contribute at most one per cycle
  assert_unit_step_R3: assert property (@(posedge clk) disable iff (rst)
    (cfg.thr != '0) |-> (inc_amt <= INC_W'(1)));

  // R1: gated-off cycles contribute nothing
  assert_gate_R1: assert property (@(posedge clk) disable iff (rst)
    (!en) |-> (inc_amt == '0));
endmodule

// File: rtl/pqc_accum.sv
module pqc_accum #(
  parameter int unsigned CNT_W = 48,
  parameter int unsigned INC_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [INC_W-1:0] inc_amt,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ovf_q
);
  logic [CNT_W:0] sum;
  logic           past_vld;

  always_comb sum = {1'b0, cnt_q} + (CNT_W+1)'(inc_amt);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      ovf_q    <= 1'b0;
      past_vld <= 1'b0;
    end else begin
      past_vld <= 1'b1;
      cnt_q    <= sum[CNT_W-1:0];
      if (clr)         ovf_q <= 1'b0;
      else if (sum[CNT_W]) ovf_q <= 1'b1;
    end
  end

  // R8: sticky flag only drops after a configuration write
  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (past_vld && $fell(ovf_q)) |-> $past(clr));

  // R7: a step never exceeds the largest per-cycle increment
  assert_bounded_step_R7: assert property (@(posedge clk) disable iff (rst)
    past_vld |-> ((cnt_q - $past(cnt_q)) <= CNT_W'((1 << INC_W) - 1)));
endmodule

// File: rtl/perf_qual_counter.sv
module perf_qual_counter
  import pqc_pkg::*;
#(
  parameter int unsigned CNT_W = 48,
  parameter int unsigned INC_W = 4,
  parameter int unsigned PL_W  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic             cfg_usr_en,
  input  logic             cfg_krn_en,
  input  logic             cfg_inv,
  input  logic             cfg_edge,
  input  logic [7:0]       cfg_thr,
  input  logic             count_en,
  input  logic [INC_W-1:0] evt_inc,
  input  logic [PL_W-1:0]  priv_lvl,
  output logic [CNT_W-1:0] cnt_val,
  output logic             ovf
);
  pqc_cfg_t         cfg_in, cfg_q;
  logic [INC_W-1:0] inc_amt;
  logic             past_vld;

  always_comb begin
    cfg_in.usr_en   = cfg_usr_en;
    cfg_in.krn_en   = cfg_krn_en;
    cfg_in.inv      = cfg_inv;
    cfg_in.edge_det = cfg_edge;
    cfg_in.thr      = cfg_thr;
  end

  pqc_cfg_reg u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .cfg_in(cfg_in), .cfg_q(cfg_q)
  );

  pqc_qualifier #(.INC_W(INC_W), .PL_W(PL_W)) u_qual (
    .clk(clk), .rst(rst), .clr(cfg_we), .cfg(cfg_q), .evt(evt_inc),
    .priv(priv_lvl), .en(count_en), .inc_amt(inc_amt)
  );

  pqc_accum #(.CNT_W(CNT_W), .INC_W(INC_W)) u_acc (
    .clk(clk), .rst(rst), .clr(cfg_we), .inc_amt(inc_amt),
    .cnt_q(cnt_val), .ovf_q(ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) past_vld <= 1'b0;
    else     past_vld <= 1'b1;
  end

  // R1: disabled cycle leaves the counter unchanged
  assert_hold_disabled_R1: assert property (@(posedge clk) disable iff (rst)
    (past_vld && $past(!count_en)) |-> $stable(cnt_val));

  // R8: write cycle leaves the counter unchanged and clears the flag
  assert_write_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (past_vld && $past(cfg_we)) |-> ($stable(cnt_val) && !ovf));
endmodule

// File: tb/perf_qual_counter_tb_top.sv
module perf_qual_counter_tb_top;
  localparam int CW = 8;
  logic clk = 0, rst = 1;
  logic cfg_we = 0, cfg_usr_en = 0, cfg_krn_en = 0, cfg_inv = 0, cfg_edge = 0;
  logic [7:0] cfg_thr = 0;
  logic count_en = 0;
  logic [3:0] evt_inc = 0;
  logic [1:0] priv_lvl = 0;
  logic [CW-1:0] cnt_val;
  logic ovf;

  int total = 0, bad = 0, cyc = 0;
  bit m_usr, m_krn, m_inv, m_edge, m_prev, m_ovf;
  int m_thr, m_cnt;

  always #10 clk = ~clk;

  perf_qual_counter #(.CNT_W(CW)) dut_i (.*);

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic string tag_of(bit allowed);
    if (!allowed) return "R1";
    if (m_edge && m_thr == 0) return "R6";
    if (m_edge) return "R5";
    if (m_inv) return "R4";
    if (m_thr != 0) return "R3";
    return "R2";
  endfunction

  task automatic step(int e, int p, bit en);
    bit hit, cond, allowed;
    int amt, s;
    evt_inc = 4'(e); priv_lvl = 2'(p); count_en = en;
    hit = (m_thr == 0) ? (e != 0) : (e >= m_thr);
    cond = hit ^ m_inv;
    allowed = en && ((p == 0) ? m_krn : m_usr);
    if (!allowed) amt = 0;
    else if (m_edge) amt = (m_thr == 0) ? 0 : int'(cond && !m_prev);
    else if (m_thr == 0 && !m_inv) amt = e;
    else amt = int'(cond);
    s = m_cnt + amt;
    if (s >= (1 << CW)) m_ovf = 1;
    m_cnt = s % (1 << CW);
    m_prev = cond;
    @(posedge clk); @(negedge clk);
    chk(tag_of(allowed), int'(cnt_val), m_cnt);
    chk("R7", int'(ovf), int'(m_ovf));
  endtask

  task automatic write_cfg(bit u, bit k, bit i, bit ed, int t);
    cfg_we = 1; cfg_usr_en = u; cfg_krn_en = k; cfg_inv = i; cfg_edge = ed;
    cfg_thr = 8'(t); count_en = 1; evt_inc = 4'd15; priv_lvl = 0;
    @(posedge clk); @(negedge clk);
    cfg_we = 0;
    m_usr = u; m_krn = k; m_inv = i; m_edge = ed; m_thr = t;
    m_prev = 0; m_ovf = 0;
    chk("R8", int'(cnt_val), m_cnt);
    chk("R8", int'(ovf), 0);
  endtask

  initial begin
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=<150000", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int thrs[6] = '{0, 1, 3, 7, 15, 16};
    m_cnt = 0; m_ovf = 0; m_prev = 0; m_thr = 0;
    m_usr = 0; m_krn = 0; m_inv = 0; m_edge = 0;
    repeat (2) @(negedge clk);
    rst = 0;
    chk("R9", int'(cnt_val), 0);
    chk("R9", int'(ovf), 0);
    step(5, 0, 1);   // reset config: both privilege enables clear
    step(5, 2, 1);
    for (int c = 0; c < 16; c++)
      for (int t = 0; t < 6; t++) begin
        write_cfg(c[0], c[1], c[2], c[3], thrs[t]);
        for (int p = 0; p < 4; p++)
          for (int n = 0; n < 16; n++) step((n * 7 + p) % 16, p, 1);
        for (int n = 0; n < 4; n++) step(n * 5, n, 0);
        step(0, 1, 1); step(15, 1, 1); step(0, 0, 1); step(15, 0, 1);
      end
    // wrap and sticky flag
    write_cfg(1, 1, 0, 0, 0);
    for (int n = 0; n < 40; n++) step(15, n % 4, 1);
    chk("R7", int'(ovf), 1);
    step(0, 0, 0);
    chk("R7", int'(ovf), 1);
    write_cfg(1, 1, 0, 0, 0);
    chk("R8", int'(ovf), 0);
    // edge history cleared by write: condition high before and after
    write_cfg(1, 1, 0, 1, 1);
    step(4, 1, 1); step(4, 1, 1);
    write_cfg(1, 1, 0, 1, 1);
    step(4, 1, 1);
    rst = 1; @(posedge clk); @(negedge clk); rst = 0;
    m_cnt = 0; m_ovf = 0;
    chk("R9", int'(cnt_val), 0);
    chk("R9", int'(ovf), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule